// File: doc/BRIEF.md
# Software Interrupt Trap Entry Controller

This block takes a processor from an unprivileged program into supervisor mode when a software interrupt instruction executes. It also brings the program back on a return request. An instruction word arrives with its condition-pass flag, its own address and the current program status word. When the word is a software interrupt and its condition passed, the controller does four things. It sends the program counter to a fixed vector. It copies the status word into a supervisor-only saved-status register. It writes the address of the following word into a supervisor-only link register. It switches the status word into supervisor mode with IRQs masked. Any other accepted word, including a software interrupt whose condition failed, only advances the program counter by one word.

Instruction words enter on a valid/ready handshake. `in_ready` is low while trap entry is in progress. A word held valid during that time waits and is not consumed: this is the only back-pressure the block applies. The return request and the result strobe are plain control pins, and the result strobe has no ready. On a return the program counter is reloaded from the link register and the status word is restored from the saved copy. The banked pair has a single level only, so a trap taken while already in supervisor mode overwrites it.

Top module: `swi_trap_ctrl`

## Requirements
- R1: A word accepted with `in_cond`=1 and bits 27:24 equal to 4'b1111 is a trap, and one cycle later `out_pc` is 32'h0000_0008.
- R2: An accepted word that is not a trap (condition failed, or bits 27:24 not 4'b1111) gives `out_pc` = `in_pc`+4 and `out_psr` = `in_psr` one cycle later, and leaves `lr_svc` and `spsr_svc` unchanged.
- R3: On a trap, `spsr_svc` receives `in_psr`. `out_psr` equals `in_psr` with bits 4:0 set to 5'b10011 and bit 7 set, and all other bits unchanged.
- R4: On a trap, `lr_svc` receives `in_pc`+4.
- R5: Bits 23:0 of the instruction word have no effect on any output.
- R6: After a trap, `busy` is high for exactly three cycles (two sequential and one non-sequential), and `in_ready` is low for the same three cycles. A word held valid during that time is not consumed.
- R7: A return request taken while `busy` is low and no word is accepted gives `out_pc` = `lr_svc` and `out_psr` = `spsr_svc` one cycle later.
- R8: A second trap overwrites `lr_svc` and `spsr_svc`. The values from the first trap are not kept.
- R9: After reset, `out_pc`, `out_psr`, `lr_svc` and `spsr_svc` are zero, and `busy` and `out_valid` are low.
- R10: When a trap is accepted in the same cycle as a return request, the trap is performed and the return is dropped.
- R11: `out_valid` pulses high for one cycle after each accepted word or taken return, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word can be accepted (low during trap entry) |
| in_instr | input | 32 | Instruction word |
| in_cond | input | 1 | Condition check of the word passed |
| in_pc | input | 32 | Address of the word |
| in_psr | input | 32 | Current program status word |
| ret_req | input | 1 | Return from supervisor request |
| out_valid | output | 1 | New PC/status are valid this cycle |
| out_pc | output | 32 | New program counter |
| out_psr | output | 32 | New program status word |
| lr_svc | output | 32 | Supervisor link register |
| spsr_svc | output | 32 | Supervisor saved-status register |
| busy | output | 1 | Trap entry in progress |

## Verification
A corrupted banked register stays hidden until a return reads it. At that point `out_pc` or `out_psr` carries the wrong value in the cycle after the request, so every trap in the stimulus is followed by a return. A wrong entry counter shows up as a `busy` window of the wrong length. It also shows up as a word consumed while `in_ready` should be low, which the scoreboard reports as an unexpected `out_valid`. A decoder that looks at the wrong bits is exposed by traps whose low 24 bits differ and by words that differ only in bits 27:24.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned TAG_HI   = 27;
  localparam int unsigned TAG_LO   = 24;
  localparam int unsigned TAG_W    = TAG_HI - TAG_LO + 1;
  localparam logic [TAG_W-1:0] TAG_TRAP = 4'b1111;
  localparam int unsigned MODE_W   = 5;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam int unsigned IRQ_MASK_BIT = 7;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_ADV  = 2'd1,
    UPD_TRAP = 2'd2,
    UPD_RET  = 2'd3
  } upd_kind_e;

  function automatic logic [XLEN-1:0] svc_psr(input logic [XLEN-1:0] psr);
    logic [XLEN-1:0] r;
    r = psr;
    r[MODE_W-1:0] = MODE_SVC;
    r[IRQ_MASK_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
(
  input  logic [TAG_W-1:0] tag,
  input  logic             cond_ok,
  output logic             is_trap
);
  always_comb begin
    is_trap = cond_ok && (tag == TAG_TRAP);
  end
endmodule

// File: rtl/swi_busy.sv
module swi_busy #(
  parameter int unsigned SEQ_CYC  = 2,
  parameter int unsigned NSEQ_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned TOTAL = SEQ_CYC + NSEQ_CYC;
  localparam int unsigned CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LOAD = CW'(TOTAL);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] link_d,
  input  logic [W-1:0] spsr_d,
  output logic [W-1:0] link_q,
  output logic [W-1:0] spsr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= '0;
      spsr_q <= '0;
    end else if (we) begin
      link_q <= link_d;
      spsr_q <= spsr_d;
    end
  end
endmodule

// File: rtl/swi_trap_ctrl.sv
module swi_trap_ctrl
  import swi_pkg::*;
#(
  parameter int unsigned SEQ_CYC  = 2,
  parameter int unsigned NSEQ_CYC = 1,
  parameter logic [31:0] VECTOR   = 32'h0000_0008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_instr,
  input  logic        in_cond,
  input  logic [31:0] in_pc,
  input  logic [31:0] in_psr,
  input  logic        ret_req,
  output logic        out_valid,
  output logic [31:0] out_pc,
  output logic [31:0] out_psr,
  output logic [31:0] lr_svc,
  output logic [31:0] spsr_svc,
  output logic        busy
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic            is_trap;
  logic            accept;
  upd_kind_e       kind;
  logic [XLEN-1:0] pc_q, psr_q;
  logic            vld_q;
  logic            unused_ok;

  // Only the tag nibble is decoded; the comment field and the top nibble are dropped.
  assign unused_ok = ^{in_instr[XLEN-1:TAG_HI+1], in_instr[TAG_LO-1:0]};

  swi_decode u_dec (
    .tag     (in_instr[TAG_HI:TAG_LO]),
    .cond_ok (in_cond),
    .is_trap (is_trap)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  // An accepted word always wins over a return in the same cycle.
  always_comb begin
    if (accept && is_trap)      kind = UPD_TRAP;
    else if (accept)            kind = UPD_ADV;
    else if (ret_req && !busy)  kind = UPD_RET;
    else                        kind = UPD_NONE;
  end

  swi_busy #(.SEQ_CYC(SEQ_CYC), .NSEQ_CYC(NSEQ_CYC)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (kind == UPD_TRAP),
    .busy  (busy)
  );

  swi_bank #(.W(XLEN)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (kind == UPD_TRAP),
    .link_d (in_pc + WORD),
    .spsr_d (in_psr),
    .link_q (lr_svc),
    .spsr_q (spsr_svc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      psr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= (kind != UPD_NONE);
      unique case (kind)
        UPD_TRAP: begin
          pc_q  <= VECTOR;
          psr_q <= svc_psr(in_psr);
        end
        UPD_ADV: begin
          pc_q  <= in_pc + WORD;
          psr_q <= in_psr;
        end
        UPD_RET: begin
          pc_q  <= lr_svc;
          psr_q <= spsr_svc;
        end
        default: ;
      endcase
    end
  end

  assign out_pc    = pc_q;
  assign out_psr   = psr_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/swi_trap_chk.sv
module swi_trap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_instr,
  input logic        in_cond,
  input logic [31:0] in_pc,
  input logic [31:0] in_psr,
  input logic        ret_req,
  input logic        out_valid,
  input logic [31:0] out_pc,
  input logic [31:0] out_psr,
  input logic [31:0] lr_svc,
  input logic [31:0] spsr_svc,
  input logic        busy
);
  logic trap_in, adv_in;
  assign trap_in = in_valid && in_ready && in_cond && (in_instr[27:24] == 4'b1111);
  assign adv_in  = in_valid && in_ready && !(in_cond && (in_instr[27:24] == 4'b1111));

  // R1
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> (out_pc == 32'h0000_0008) && out_valid);

  // R3
  trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> (spsr_svc == $past(in_psr)) && (out_psr[4:0] == 5'b10011) && out_psr[7]);

  // R4
  trap_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> (lr_svc == $past(in_pc) + 32'd4));

  // R6
  entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> busy ##1 busy ##1 busy ##1 !busy);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_in |=> (out_pc == $past(in_pc) + 32'd4) && $stable(lr_svc) && $stable(spsr_svc));

  // R7
  return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !busy && !in_valid) |=> (out_pc == $past(lr_svc)) && (out_psr == $past(spsr_svc)));

  // R11
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !(ret_req && !busy)) |=> !out_valid);
endmodule

bind swi_trap_ctrl swi_trap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_instr(in_instr), .in_cond(in_cond), .in_pc(in_pc), .in_psr(in_psr),
  .ret_req(ret_req), .out_valid(out_valid), .out_pc(out_pc), .out_psr(out_psr),
  .lr_svc(lr_svc), .spsr_svc(spsr_svc), .busy(busy)
);

// File: tb/sim_swi_trap_ctrl.sv
`timescale 1ns/1ps
module sim_swi_trap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        in_cond = 1'b0;
  logic [31:0] in_pc = '0;
  logic [31:0] in_psr = '0;
  logic        ret_req = 1'b0;
  logic        out_valid;
  logic [31:0] out_pc, out_psr, lr_svc, spsr_svc;
  logic        busy;

  always #4 clk = ~clk;

  swi_trap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_cond(in_cond), .in_pc(in_pc), .in_psr(in_psr),
    .ret_req(ret_req), .out_valid(out_valid), .out_pc(out_pc), .out_psr(out_psr),
    .lr_svc(lr_svc), .spsr_svc(spsr_svc), .busy(busy)
  );

  typedef struct {
    logic [31:0] pc, psr, lr, spsr;
    int          req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] m_lr = '0, m_spsr = '0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per result strobe.
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected strobe", {31'd0, out_valid}, 32'd0);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = $sformatf("R%0d", e.req);
        check(out_pc == e.pc, {t, " pc"}, out_pc, e.pc);
        check(out_psr == e.psr, {t, " psr"}, out_psr, e.psr);
        check(lr_svc == e.lr, {t, " lr"}, lr_svc, e.lr);
        check(spsr_svc == e.spsr, {t, " spsr"}, spsr_svc, e.spsr);
      end
    end
  end

  // Driver: offers one word, pushes the expected result.
  task automatic send(input logic [31:0] instr, input logic cond, input logic [31:0] pc,
                      input logic [31:0] psr, input int req, input logic with_ret);
    exp_t e;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_instr = instr; in_cond = cond; in_pc = pc; in_psr = psr;
    ret_req = with_ret;
    if (cond && instr[27:24] == 4'b1111) begin
      m_lr = pc + 32'd4;
      m_spsr = psr;
      e.pc = 32'h8;
      e.psr = {psr[31:8], 1'b1, psr[6:5], 5'b10011};
    end else begin
      e.pc = pc + 32'd4;
      e.psr = psr;
    end
    e.lr = m_lr; e.spsr = m_spsr; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; ret_req = 1'b0;
  endtask

  task automatic do_ret(input int req);
    exp_t e;
    while (busy) @(negedge clk);
    ret_req = 1'b1;
    e.pc = m_lr; e.psr = m_spsr; e.lr = m_lr; e.spsr = m_spsr; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(out_pc == 0, "R9 pc", out_pc, 0);
    check(out_psr == 0, "R9 psr", out_psr, 0);
    check(lr_svc == 0 && spsr_svc == 0, "R9 banks", lr_svc | spsr_svc, 0);
    check(!busy && !out_valid, "R9 busy/valid", {30'd0, busy, out_valid}, 0);

    // R2 plain advance, and failed-condition trap word
    send(32'hE1A0_0001, 1'b1, 32'h0000_1000, 32'h6000_0010, 2, 1'b0);
    send(32'h0F00_0000, 1'b0, 32'h0000_1004, 32'h2000_0010, 2, 1'b0);
    send(32'hEE00_1234, 1'b1, 32'h0000_1008, 32'h0000_001F, 2, 1'b0);
    check(!busy, "R2 no busy", {31'd0, busy}, 0);

    // R1 R3 R4 trap, then R6 back-pressure window
    send(32'hEF00_00AA, 1'b1, 32'h0000_2000, 32'hF000_0010, 1, 1'b0);
    check(busy && !in_ready, "R6 c1", {30'd0, busy, in_ready}, 32'd2);
    in_valid = 1'b1; in_instr = 32'hE1A0_0000; in_cond = 1'b1; in_pc = 32'h0000_9000;
    @(negedge clk);
    check(busy && !in_ready, "R6 c2", {30'd0, busy, in_ready}, 32'd2);
    @(negedge clk);
    check(busy && !in_ready, "R6 c3", {30'd0, busy, in_ready}, 32'd2);
    @(negedge clk);
    check(!busy && in_ready, "R6 end", {30'd0, busy, in_ready}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_pc == 32'h8, "R6 held word not taken", out_pc, 32'h8);

    // R7 return restores
    do_ret(7);
    settle();

    // R5 comment field ignored: same trap with different low bits
    send(32'hEF12_3456, 1'b1, 32'h0000_3000, 32'h0000_0010, 5, 1'b0);
    settle();
    do_ret(5);
    send(32'hEFFF_FFFF, 1'b1, 32'h0000_3000, 32'h0000_0010, 5, 1'b0);
    settle();
    do_ret(5);

    // R8 nested trap overwrites banks
    send(32'hEF00_0001, 1'b1, 32'h0000_4000, 32'h0000_0010, 8, 1'b0);
    send(32'hEF00_0002, 1'b1, 32'h0000_0100, 32'h0000_0093, 8, 1'b0);
    settle();
    do_ret(8);

    // R10 trap wins over same-cycle return
    send(32'h1F00_0000, 1'b1, 32'h0000_5000, 32'h8000_0010, 10, 1'b1);
    settle();
    check(sb.size() == 0, "R11 all results seen", sb.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule